// File: doc/BRIEF.md
# CRC Hash Address Filter

This block decides whether the destination address of a received frame falls into a 512-bucket hash filter. The six address bytes arrive one at a time on a byte-valid interface, in the order they appear on the wire. A start-of-frame pulse clears the running state before each address. A reflected CRC-32 is folded over the bytes, and the 32-bit result is bit-reversed. A bucket index is then taken from the top of the reversed value. The table bit at that bucket gives a single hit or miss result.

The group bit of the address and a mode input decide how the bucket is formed. In normal mode, eight CRC bits pick a bucket, and the group bit chooses between the individual half and the group half of the table. In extended mode, nine CRC bits cover the whole table. That table is meant for group addresses only, so an individual address in this mode always misses. A write port lets software set or clear any single bucket bit.

Top module: `crc_hash_filter`

## Requirements
- R1: After reset, `hit_valid` and `hit` are 0 and every table bit is 0. A lookup of any address therefore misses until a bucket is written.
- R2: The CRC starts at 0xFFFFFFFF. It is updated LSB-first for each byte with the reflected polynomial 0xEDB88320, with the first byte received taken first. By default no final inversion is applied, and the 32-bit result is then bit-reversed (bit 0 swaps with bit 31).
- R3: With `ext_mode`=0, the bucket is {group bit, reversed CRC bits 31..24}. An individual address uses buckets 0..255, and a group address uses buckets 256..511.
- R4: With `ext_mode`=1, the bucket is reversed CRC bits 31..23. Bucket bits 8..5 name the hash word and bits 4..0 name the bit within it.
- R5: With `ext_mode`=1, an individual address reports `hit`=0, whatever the table holds.
- R6: The group bit is bit 0 of the first address byte received; 1 means group.
- R7: `hit_valid` goes to 1 one cycle after the sixth byte is accepted. `hit` and `hit_valid` then hold until a `sof` pulse, and in the cycle after that pulse both read 0.
- R8: A byte presented in the same cycle as `sof` is not taken. Bytes presented after the sixth, and before the next `sof`, are also ignored.
- R9: A write with `wr_en`=1 sets table bit `wr_bucket` to `wr_set` from the next cycle on.
- R10: If a write lands in the same cycle as the sixth byte, the lookup of that bucket returns the table value from before the write.
- R11: `ext_mode` is sampled in the cycle the sixth byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse; clears the CRC, byte count and result |
| byte_valid | input | 1 | `byte_data` carries an address byte |
| byte_data | input | 8 | Address byte, in wire order |
| ext_mode | input | 1 | 1 = extended group hashing, 0 = normal hashing |
| wr_en | input | 1 | Table write strobe |
| wr_bucket | input | 9 | Bucket index to write |
| wr_set | input | 1 | Value written to the bucket bit |
| hit | output | 1 | Lookup result |
| hit_valid | output | 1 | `hit` holds the result for the current address |

## Verification
The assertions assume three things about the inputs:
- `sof` is a single-cycle pulse that comes before each address.
- `ext_mode` is settled in the cycle of the sixth byte.
- Write indices stay within the 512 buckets.

The stimulus meets these assumptions: every frame is sent through one task, which raises `sof` for exactly one cycle, drives the bytes and mode on the falling edge, and takes bucket numbers only from the bench's own CRC model. Gaps between bytes, extra bytes and a byte presented alongside `sof` are all driven on purpose; they stay within what the design must tolerate.

// File: rtl/crc_hash_filter.sv
module crc_hash_filter #(
  parameter int          ADDR_BYTES   = 6,
  parameter int          BKT_W        = 9,
  parameter logic [31:0] POLY         = 32'hEDB88320,
  parameter bit          FINAL_INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             ext_mode,
  input  logic             wr_en,
  input  logic [BKT_W-1:0] wr_bucket,
  input  logic             wr_set,
  output logic             hit,
  output logic             hit_valid
);
  localparam int TBL_SIZE = 1 << BKT_W;
  localparam int CNT_W    = $clog2(ADDR_BYTES + 1);

  logic [31:0]       crc_q, crc_nx, crc_fin, crc_rev;
  logic [CNT_W-1:0]  cnt_q;
  logic              grp_q, grp_now, take, last, look;
  logic [BKT_W-1:0]  bucket;
  logic [TBL_SIZE-1:0] tbl_q;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  assign take    = byte_valid && !sof && (cnt_q < CNT_W'(ADDR_BYTES));
  assign last    = take && (cnt_q == CNT_W'(ADDR_BYTES - 1));
  assign crc_nx  = crc_step(crc_q, byte_data);
  assign crc_fin = FINAL_INVERT ? ~crc_nx : crc_nx;
  assign grp_now = (cnt_q == '0) ? byte_data[0] : grp_q;

  always_comb
    for (int i = 0; i < 32; i++) crc_rev[i] = crc_fin[31-i];

  assign bucket = ext_mode ? crc_rev[31 -: BKT_W] : {grp_now, crc_rev[31 -: BKT_W-1]};
  assign look   = tbl_q[bucket] && !(ext_mode && !grp_now);

  always_ff @(posedge clk) begin
    if (!rst_n || sof) begin
      crc_q     <= '1;
      cnt_q     <= '0;
      grp_q     <= 1'b0;
      hit       <= 1'b0;
      hit_valid <= 1'b0;
    end else if (take) begin
      crc_q <= crc_nx;
      cnt_q <= cnt_q + CNT_W'(1);
      grp_q <= grp_now;
      if (last) begin
        hit       <= look;
        hit_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      tbl_q <= '0;
    else if (wr_en)
      tbl_q[wr_bucket] <= wr_set;
  end
endmodule

module crc_hash_filter_chk #(
  parameter int BKT_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sof,
  input logic                    byte_valid,
  input logic                    ext_mode,
  input logic                    wr_en,
  input logic [BKT_W-1:0]        wr_bucket,
  input logic                    wr_set,
  input logic                    hit,
  input logic                    hit_valid,
  input logic                    grp_q,
  input logic [(1<<BKT_W)-1:0]   tbl_q
);
  assert_hit_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> hit_valid);

  assert_sof_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !hit_valid && !hit);

  assert_result_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && !sof |=> hit_valid && $stable(hit));

  assert_rise_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_valid) |-> $past(byte_valid) && !$past(sof));

  assert_ext_unicast_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_valid) && $past(ext_mode) && !grp_q |-> !hit);

  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl_q[$past(wr_bucket)] == $past(wr_set));
endmodule

bind crc_hash_filter crc_hash_filter_chk #(.BKT_W(BKT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sof(sof), .byte_valid(byte_valid),
  .ext_mode(ext_mode), .wr_en(wr_en), .wr_bucket(wr_bucket), .wr_set(wr_set),
  .hit(hit), .hit_valid(hit_valid), .grp_q(grp_q), .tbl_q(tbl_q)
);

// File: tb/crc_hash_filter_tb.sv
module crc_hash_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0, byte_valid = 1'b0, ext_mode = 1'b0;
  logic [7:0] byte_data = '0;
  logic       wr_en = 1'b0, wr_set = 1'b0;
  logic [8:0] wr_bucket = '0;
  logic       hit, hit_valid;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  crc_hash_filter dut_i (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_valid(byte_valid),
    .byte_data(byte_data), .ext_mode(ext_mode), .wr_en(wr_en),
    .wr_bucket(wr_bucket), .wr_set(wr_set), .hit(hit), .hit_valid(hit_valid)
  );

  // {address (first byte in bits 47:40), ext_mode}
  localparam logic [48:0] VEC [0:7] = '{
    {48'h01005E000001, 1'b0}, {48'h001122334455, 1'b0},
    {48'h333300000001, 1'b0}, {48'h020000FF00FF, 1'b0},
    {48'h0180C2000001, 1'b1}, {48'hFFFFFFFFFFFF, 1'b1},
    {48'h00A0C9123456, 1'b1}, {48'h0E1111111111, 1'b1}
  };

  function automatic logic [31:0] ref_rev(input logic [47:0] a);
    logic [31:0] c, r;
    c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      c = c ^ {24'h0, a[47-8*b -: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    for (int k = 0; k < 32; k++) r[k] = c[31-k];
    return r;
  endfunction

  function automatic logic [8:0] ref_bucket(input logic [47:0] a, input logic ext);
    logic [31:0] r;
    r = ref_rev(a);
    return ext ? r[31:23] : {a[40], r[31:24]};
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic write_bkt(input logic [8:0] b, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_bucket = b; wr_set = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [47:0] a, input logic ext_first, input logic ext_last,
                      input bit gaps, input bit sof_byte, input bit collide, input logic [8:0] cb);
    @(negedge clk);
    sof = 1'b1; byte_valid = sof_byte; byte_data = 8'hA5;
    @(negedge clk);
    sof = 1'b0;
    for (int i = 0; i < 6; i++) begin
      byte_valid = 1'b1;
      byte_data  = a[47-8*i -: 8];
      ext_mode   = (i == 5) ? ext_last : ext_first;
      if (collide && i == 5) begin wr_en = 1'b1; wr_bucket = cb; wr_set = 1'b1; end
      @(negedge clk);
      wr_en = 1'b0;
      if (gaps && i < 5) begin byte_valid = 1'b0; @(negedge clk); end
    end
    byte_valid = 1'b0;
  endtask

  initial begin
    for (int n = 0; n < 100000 && !done; n++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    logic [8:0]  b;
    logic        ext, grp, exp_hit;
    repeat (3) @(negedge clk);
    check(hit_valid, 1'b0, "R1 hit_valid after reset");
    check(hit, 1'b0, "R1 hit after reset");
    rst_n = 1'b1;

    foreach (VEC[v]) begin
      a = VEC[v][48:1]; ext = VEC[v][0]; grp = a[40];
      b = ref_bucket(a, ext);
      exp_hit = !(ext && !grp);
      send(a, ext, ext, 1'b0, 1'b0, 1'b0, '0);
      check(hit_valid, 1'b1, "R7 result valid after sixth byte");
      check(hit, 1'b0, "R1 empty table misses");
      write_bkt(b, 1'b1);
      send(a, ext, ext, v[0], 1'b0, 1'b0, '0);
      check(hit, exp_hit, ext ? (grp ? "R4 extended bucket" : "R5 extended unicast miss")
                              : (grp ? "R3 R6 group half" : "R2 R3 R6 individual half"));
      write_bkt(b, 1'b0);
      if (!ext) begin
        write_bkt(b ^ 9'h100, 1'b1);
        send(a, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        check(hit, 1'b0, "R3 opposite half not used");
        write_bkt(b ^ 9'h100, 1'b0);
      end
      send(a, ext, ext, 1'b0, 1'b0, 1'b0, '0);
      check(hit, 1'b0, "R9 cleared bucket misses");
    end

    a = 48'h01005E7F0102;
    b = ref_bucket(a, 1'b0);
    write_bkt(b, 1'b1);
    send(a, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    check(hit, 1'b1, "R8 byte alongside sof ignored");
    byte_valid = 1'b1; byte_data = 8'h3C;
    @(negedge clk);
    byte_valid = 1'b0;
    @(negedge clk);
    check(hit, 1'b1, "R8 seventh byte ignored");
    check(hit_valid, 1'b1, "R7 result held");
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    check(hit_valid, 1'b0, "R7 sof clears hit_valid");
    check(hit, 1'b0, "R7 sof clears hit");

    b = ref_bucket(a, 1'b1);
    write_bkt(ref_bucket(a, 1'b0), 1'b0);
    write_bkt(b, 1'b1);
    send(a, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    check(hit, 1'b1, "R11 mode taken at sixth byte");
    send(a, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    check(hit, (ref_bucket(a, 1'b0) == b), "R11 mode taken at sixth byte");
    write_bkt(b, 1'b0);

    b = ref_bucket(a, 1'b0);
    send(a, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, b);
    check(hit, 1'b0, "R10 same-cycle write returns old value");
    send(a, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    check(hit, 1'b1, "R10 write visible on next lookup");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule